// File: doc/BRIEF.md
# Register-List Stack Save/Restore Sequencer

This block saves a chosen group of registers onto a downward-growing stack, or restores them from it, in response to a single start command. The command carries an 8-bit selection mask, a bank choice (the lower or the upper eight registers of a sixteen-entry file), a width choice (16-bit words or 8-bit bytes), a direction (save or restore) and the starting stack pointer. The sequencer then works through the selected registers one at a time. For each one it makes a single access on a request/acknowledge memory port and either reads the register file (save) or writes it (restore) through one shared register port.

Every stack slot is two bytes wide, even when byte registers are moved, so the pointer always moves by two per register. A save walks the mask from the highest bit down and pre-decrements the pointer before each write. A restore walks it from the lowest bit up, reading at the pointer and then stepping it up. Each access address is tagged with a region flag: addresses below 0x2000 are internal data memory and all others are external memory. The final pointer is published once, together with a single-cycle completion pulse.

Top module: `rls_seq`

## Requirements
- R1: Mask bit i selects register i of the chosen bank; the register port index is {bank, i}, so bank 0 reaches indices 0..7 and bank 1 reaches indices 8..15.
- R2: A save (is_pop=0) visits the selected registers from mask bit 7 down to bit 0. Each access is a write (mem_we=1) at the current pointer minus 2, and the pointer becomes that address.
- R3: A restore (is_pop=1) visits the selected registers from mask bit 0 up to bit 7. Each access is a read (mem_we=0) at the current pointer, and the pointer then grows by 2.
- R4: With word_mode=0 the pointer still moves by 2 per register, and a save writes the register's low byte zero-extended to 16 bits.
- R5: A restore writes the register (rf_we=1) in the cycle its read is acknowledged. With word_mode=1 it writes the full read word; with word_mode=0 it writes only the low 8 bits, zero-extended.
- R6: mem_ext is 1 exactly when mem_addr is 0x2000 or above, and 0 below it.
- R7: Each selected register gets exactly one access. Request, address, write data and register index hold steady until mem_ack, and the next register is taken only after it.
- R8: done is a one-cycle pulse after the last access. In that cycle sp_out equals the start pointer moved by 2 per selected register (down for save, up for restore), and it keeps that value until the next start.
- R9: An all-zero mask raises done in the cycle right after start is taken, makes no memory access, and leaves sp_out equal to sp_in.
- R10: start is ignored while busy is 1: the running operation's accesses and final pointer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts an operation when idle |
| is_pop | input | 1 | 1 = restore from stack, 0 = save to stack |
| upper_bank | input | 1 | 1 = registers 8..15, 0 = registers 0..7 |
| word_mode | input | 1 | 1 = 16-bit registers, 0 = 8-bit registers |
| reg_mask | input | 8 | Register selection mask |
| sp_in | input | 16 | Stack pointer at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| sp_out | output | 16 | Final stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_ext | output | 1 | 1 = external region, 0 = internal |
| mem_addr | output | 16 | Access byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| rf_idx | output | 4 | Register file index |
| rf_rdata | input | 16 | Register file read data for rf_idx |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 16 | Register file write data |

## Verification
The assertions take for granted that mem_ack is only raised while mem_req is high and lasts one cycle per access, and that mem_rdata is valid in the acknowledge cycle. The bench's memory responder enforces this. It raises acknowledge for a single cycle after a random wait of zero to two cycles, and only against a pending request. It drops it in the following cycle before the next request can be seen. Start commands go in only while idle, except in the one directed case that checks they are ignored while busy. Stack pointers are kept even, as the two-byte slot layout expects.

// File: rtl/rls_pkg.sv
package rls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } rls_state_e;

  localparam int SLOT_BYTES = 2;
endpackage

// File: rtl/rls_mask_pick.sv
module rls_mask_pick #(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  input  logic            low_first,
  output logic [IW-1:0]   idx,
  output logic            any
);
  logic [IW-1:0] lo_idx, hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IW'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (mask[i]) hi_idx = IW'(i);
    end
  end

  assign idx = low_first ? lo_idx : hi_idx;
  assign any = |mask;

  always_comb begin
    if (any) a_r7_pick_live: assert (mask[idx]);
  end
endmodule

// File: rtl/rls_region.sv
module rls_region #(
  parameter int AW = 16,
  parameter int EXT_BASE = 'h2000
) (
  input  logic [AW-1:0] addr,
  output logic          ext
);
  assign ext = (addr >= AW'(EXT_BASE));
endmodule

// File: rtl/rls_seq.sv
module rls_seq
  import rls_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NREG = 8,
  parameter int BYTE_W = 8,
  parameter int EXT_BASE = 'h2000,
  localparam int IW = $clog2(NREG),
  localparam int RW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_pop,
  input  logic            upper_bank,
  input  logic            word_mode,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   sp_in,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   sp_out,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_ext,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic [RW-1:0]   rf_idx,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [DW-1:0]   rf_wdata
);
  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] v, input logic full);
    return full ? v : {{(DW-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
  endfunction

  function automatic logic [AW-1:0] slot_move(input logic [AW-1:0] sp, input logic up);
    return up ? sp + AW'(SLOT_BYTES) : sp - AW'(SLOT_BYTES);
  endfunction

  function automatic logic [AW-1:0] final_sp(input logic [AW-1:0] sp,
                                             input logic [NREG-1:0] m,
                                             input logic up);
    logic [AW-1:0] span;
    span = AW'($countones(m) * SLOT_BYTES);
    return up ? sp + span : sp - span;
  endfunction

  rls_state_e      state;
  logic [NREG-1:0] pend, start_mask;
  logic [AW-1:0]   sp_cur, start_sp;
  logic            op_pop, op_bank, op_word;

  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic            xfer_fire;
  logic [NREG-1:0] pend_next;
  logic [AW-1:0]   acc_addr;

  rls_mask_pick #(.NREG(NREG)) u_pick (
    .mask      (pend),
    .low_first (op_pop),
    .idx       (pick_idx),
    .any       (pick_any)
  );

  assign acc_addr = op_pop ? sp_cur : slot_move(sp_cur, 1'b0);

  rls_region #(.AW(AW), .EXT_BASE(EXT_BASE)) u_region (
    .addr (acc_addr),
    .ext  (mem_ext)
  );

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign sp_out    = sp_cur;
  assign mem_req   = (state == ST_XFER);
  assign mem_we    = ~op_pop;
  assign mem_addr  = acc_addr;
  assign mem_wdata = narrow(rf_rdata, op_word);
  assign rf_idx    = {op_bank, pick_idx};
  assign xfer_fire = mem_req & mem_ack;
  assign rf_we     = xfer_fire & op_pop;
  assign rf_wdata  = narrow(mem_rdata, op_word);
  assign pend_next = pend & ~(NREG'(1) << pick_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend       <= '0;
      start_mask <= '0;
      sp_cur     <= '0;
      start_sp   <= '0;
      op_pop     <= 1'b0;
      op_bank    <= 1'b0;
      op_word    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          pend       <= reg_mask;
          start_mask <= reg_mask;
          sp_cur     <= sp_in;
          start_sp   <= sp_in;
          op_pop     <= is_pop;
          op_bank    <= upper_bank;
          op_word    <= word_mode;
          state      <= (reg_mask == '0) ? ST_FIN : ST_XFER;
        end
        ST_XFER: if (xfer_fire) begin
          sp_cur <= op_pop ? slot_move(sp_cur, 1'b1) : acc_addr;
          pend   <= pend_next;
          if (pend_next == '0) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: request and its payload stay put until acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(rf_idx) && $stable(mem_we));

  // R7: every acknowledge retires exactly one selected register
  a_r7_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> $countones(pend) == $countones($past(pend)) - 1);

  // R2/R3: pointer moves by one slot per acknowledged access
  a_r3_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> sp_cur == ($past(op_pop) ? $past(sp_cur) + AW'(SLOT_BYTES)
                                           : $past(sp_cur) - AW'(SLOT_BYTES)));

  // R8: final pointer reflects the number of selected registers
  a_r8_final_sp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sp_out == final_sp(start_sp, start_mask, op_pop));

  // R8: completion lasts one cycle
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R9: empty mask finishes at once
  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && reg_mask == '0 |=> done);

  // R5: register writes only happen on acknowledged restores
  a_r5_rf_only_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_req && op_pop && mem_ack);
endmodule

// File: tb/tb_rls_seq.sv
module tb_rls_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_pop = 1'b0, upper_bank = 1'b0, word_mode = 1'b0;
  logic [7:0]  reg_mask = '0;
  logic [15:0] sp_in = '0;
  logic        busy, done, mem_req, mem_we, mem_ext, rf_we;
  logic [15:0] sp_out, mem_addr, mem_wdata, rf_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [3:0]  rf_idx;
  logic [15:0] rf_rdata;

  logic [15:0] rf [16];
  int checks = 0, errors = 0;
  int wait_cnt = 0;

  logic [15:0] lg_addr [8];
  logic [15:0] lg_data [8];
  logic        lg_we [8], lg_ext [8], lg_rfwe [8];
  logic [3:0]  lg_idx [8];
  int          n_log;

  always #(CLK_PERIOD/2) clk = ~clk;

  rls_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_pop(is_pop),
    .upper_bank(upper_bank), .word_mode(word_mode), .reg_mask(reg_mask),
    .sp_in(sp_in), .busy(busy), .done(done), .sp_out(sp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ext(mem_ext), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata)
  );

  assign rf_rdata = rf[rf_idx];

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder and access logger
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        if (n_log < 8) begin
          lg_addr[n_log] = mem_addr;
          lg_we[n_log]   = mem_we;
          lg_ext[n_log]  = mem_ext;
          lg_idx[n_log]  = rf_idx;
          lg_data[n_log] = mem_we ? mem_wdata : 16'h0;
        end
        mem_rdata = pat(mem_addr);
        mem_ack = 1'b1;
        #1;
        if (n_log < 8) begin
          lg_rfwe[n_log] = rf_we;
          if (!mem_we) lg_data[n_log] = rf_wdata;
        end
        n_log++;
        wait_cnt = $urandom % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  always @(posedge clk) if (rf_we) rf[rf_idx] <= rf_wdata;

  task automatic run_op(input logic pop, input logic bank, input logic wd,
                        input logic [7:0] m, input logic [15:0] sp, input logic poke);
    logic [15:0] esp, exp_data;
    logic [3:0]  ridx;
    int k, cyc, wexp;
    logic [15:0] snap [16];
    for (int r = 0; r < 16; r++) snap[r] = rf[r];
    n_log = 0;
    @(negedge clk);
    is_pop = pop; upper_bank = bank; word_mode = wd; reg_mask = m; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == 8'h00) begin
      check("R9", "done right after start", done, 1'b1);
      check("R9", "sp unchanged", sp_out, sp);
    end
    cyc = 0;
    while (!done && cyc < 200) begin
      if (poke && cyc == 2) begin
        start = 1'b1; reg_mask = 8'hFF; is_pop = ~pop; sp_in = 16'h7770;
        @(negedge clk);
        start = 1'b0;
      end else @(negedge clk);
      cyc++;
    end
    check("R8", "done reached", done, 1'b1);
    // expected walk
    esp = sp; k = 0;
    for (int s = 0; s < 8; s++) begin
      int i;
      i = pop ? s : 7 - s;
      if (m[i]) begin
        ridx = {bank, 3'(i)};
        if (!pop) esp = esp - 16'd2;
        if (k < 8) begin
          check(pop ? "R3" : "R2", "access addr", lg_addr[k], esp);
          check(pop ? "R3" : "R2", "access dir", lg_we[k], !pop);
          check("R1", "register index", lg_idx[k], ridx);
          check("R6", "region flag", lg_ext[k], esp >= 16'h2000);
          if (pop) begin
            exp_data = wd ? pat(esp) : {8'h00, pat(esp)[7:0]};
            check("R5", "restore write enable", lg_rfwe[k], 1'b1);
            check("R5", "restore data", lg_data[k], exp_data);
          end else begin
            exp_data = wd ? snap[ridx] : {8'h00, snap[ridx][7:0]};
            check("R4", "save data", lg_data[k], exp_data);
          end
        end
        if (pop) esp = esp + 16'd2;
        k++;
      end
    end
    wexp = k;
    check(poke ? "R10" : "R7", "access count", n_log, wexp);
    check(poke ? "R10" : "R8", "final sp", sp_out, esp);
    @(negedge clk);
    check("R8", "done single pulse", {busy, done}, 2'b00);
    check("R8", "sp held", sp_out, esp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 16; r++) rf[r] = 16'h1000 * 16'(r) + 16'h0A5 + 16'(r);
    n_log = 0;
    repeat (3) @(negedge clk);
    check("R8", "reset busy", busy, 1'b0);
    check("R8", "reset done", done, 1'b0);
    check("R7", "reset req", mem_req, 1'b0);
    check("R8", "reset sp", sp_out, 16'h0);
    rst_n = 1'b1;
    // directed corners
    run_op(1'b0, 1'b0, 1'b1, 8'h00, 16'h3000, 1'b0);  // R9 empty save
    run_op(1'b1, 1'b1, 1'b0, 8'h00, 16'h1234, 1'b0);  // R9 empty restore
    run_op(1'b0, 1'b0, 1'b1, 8'hFF, 16'h2008, 1'b0);  // R6 crosses region edge
    run_op(1'b1, 1'b0, 1'b1, 8'hFF, 16'h1FF8, 1'b0);  // R6 restore across edge
    run_op(1'b0, 1'b1, 1'b0, 8'hA5, 16'h2400, 1'b0);  // R4 byte save upper bank
    run_op(1'b1, 1'b1, 1'b0, 8'h81, 16'h1FFE, 1'b0);  // R5 byte restore
    run_op(1'b0, 1'b0, 1'b1, 8'h3C, 16'h0800, 1'b1);  // R10 start while busy
    run_op(1'b1, 1'b0, 1'b1, 8'h01, 16'h0002, 1'b0);
    run_op(1'b0, 1'b0, 1'b1, 8'h80, 16'h0000, 1'b0);  // pointer wrap
    for (int t = 0; t < 60; t++) begin
      run_op(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
             16'($urandom) & 16'h3FFE, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule